// File: doc/BRIEF.md
# Framebuffer Fill Engine with Display-Priority Memory Port

This block sits beside a framebuffer display controller. It holds the controller's settings: framebuffer base address, resolution mode and background colour. It also adds a hardware engine that fills a rectangular-free, linear region of memory with the background colour. Software writes a region start address and then a pixel count. The write of the count launches the fill. The engine then issues 64-byte write bursts on a shared memory command port, with a write-data stream behind each command. When the last beat has been taken, the engine raises an interrupt. The interrupt stays up until software acknowledges it.

The display fetch path shares the same command port and always wins. While the display presents a read request, the port carries that request, and the fill engine's command waits. Both memory channels are valid/ready. A request counts as transferred in a cycle where valid and ready are both high. The memory side may hold ready low for any number of cycles. Once the engine raises a valid, it keeps it, and keeps its payload, until the transfer happens. Pixels are 16 bits, two per 32-bit data beat. Each burst has sixteen beats. A last burst that is only partly inside the region masks its unused pixels through byte strobes.

Top module: `fb_fill_engine`

## Requirements
- R1: After reset, every register reads zero, `clr_busy` and `irq` are low, and neither the write command nor the write data is valid.
- R2: Register word offsets are: 0 framebuffer base, 1 resolution mode, 2 background colour (bits 15:0), 3 fill start address, 4 fill pixel count, 5 status (bit 0 busy, bit 1 interrupt pending). In the base and start address, bits 5:0 are dropped and read as zero.
- R3: Mode 0 gives 640x480, 1 gives 640x240, 2 gives 320x480 and 3 gives 320x240 on `active_w`/`active_h`.
- R4: A write of a nonzero count at offset 4 while idle starts a fill, and `clr_busy` is high from the next cycle. A count of zero starts nothing.
- R5: A fill of N pixels issues ceil(N/32) write commands, at the start address plus 64*k in ascending order. Each command is followed by exactly 16 data beats, and the next command is not offered before those beats have gone. Every beat carries the background colour captured at launch in both halves, so later colour writes do not change it.
- R6: Pixel 0 of a beat occupies bytes 1:0 (strobe bits 1:0) and pixel 1 occupies bytes 3:2. A pixel at or beyond the count has its strobes low.
- R7: While `disp_valid` is high, the memory command is a read of `disp_addr`, `disp_ready` follows `mem_cmd_ready`, and no fill command is transferred.
- R8: A count write while a fill is busy is ignored. The count register and the running fill are unchanged.
- R9: `irq` rises, and `clr_busy` falls, in the cycle after the last data beat is taken. `irq` stays high until a status write with bit 1 set. If that write lands in the completing cycle, the interrupt stays set.
- R10: The fill command and the write data, once valid, stay valid with a stable address until taken. Nothing is offered on either channel while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| fb_base | output | 32 | Framebuffer base, 64-byte aligned |
| res_mode | output | 2 | Resolution mode |
| active_w | output | 10 | Decoded visible width |
| active_h | output | 9 | Decoded visible height |
| bg_color | output | 16 | Background colour |
| disp_valid | input | 1 | Display read request valid |
| disp_ready | output | 1 | Display read request accepted |
| disp_addr | input | 32 | Display read address |
| mem_cmd_valid | output | 1 | Memory burst command valid |
| mem_cmd_ready | input | 1 | Memory burst command ready |
| mem_cmd_write | output | 1 | 1 for a fill write, 0 for a display read |
| mem_cmd_addr | output | 32 | Burst byte address |
| mem_wvalid | output | 1 | Write data beat valid |
| mem_wready | input | 1 | Write data beat ready |
| mem_wdata | output | 32 | Write data, two pixels |
| mem_wstrb | output | 4 | Byte strobes |
| clr_busy | output | 1 | Fill in progress |
| irq | output | 1 | Fill-complete interrupt |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 16-bit pixels on a 32-bit beat, 64-byte bursts and a 20-bit count. These make a burst sixteen beats and 32 pixels. That size lets fills of 1, 45 and 64 pixels cover a lone masked beat, a partial last burst with a half-strobed beat, and whole bursts, all in a few hundred cycles. Stalling ready patterns and periodic display requests put the priority rule and the hold rules under pressure during those same fills.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
  localparam logic [2:0] REG_BASE   = 3'd0;
  localparam logic [2:0] REG_MODE   = 3'd1;
  localparam logic [2:0] REG_BG     = 3'd2;
  localparam logic [2:0] REG_START  = 3'd3;
  localparam logic [2:0] REG_COUNT  = 3'd4;
  localparam logic [2:0] REG_STATUS = 3'd5;
  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_IRQ_BIT  = 1;

  typedef enum logic [1:0] {FS_IDLE, FS_CMD, FS_DATA} fill_state_e;
endpackage

// File: rtl/fbc_regs.sv
module fbc_regs
  import fbc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int REG_W      = 32,
  parameter int PIX_W      = 16,
  parameter int CNT_W      = 20,
  parameter int ALIGN_BITS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              busy,
  input  logic              done,
  output logic [ADDR_W-1:0] fb_base,
  output logic [1:0]        res_mode,
  output logic [9:0]        active_w,
  output logic [8:0]        active_h,
  output logic [PIX_W-1:0]  bg_color,
  output logic [ADDR_W-1:0] clr_start,
  output logic [CNT_W-1:0]  clr_count,
  output logic              start,
  output logic              irq
);
  logic wr_count, wr_ack;
  logic [ADDR_W-1:0] aligned_wdata;

  assign aligned_wdata = {reg_wdata[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
  assign wr_count = reg_wr && (reg_addr == REG_COUNT);
  assign wr_ack   = reg_wr && (reg_addr == REG_STATUS) && reg_wdata[STAT_IRQ_BIT];
  assign start    = wr_count && !busy && (reg_wdata[CNT_W-1:0] != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_base   <= '0;
      res_mode  <= '0;
      bg_color  <= '0;
      clr_start <= '0;
      clr_count <= '0;
      irq       <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == REG_BASE)  fb_base   <= aligned_wdata;
      if (reg_wr && reg_addr == REG_MODE)  res_mode  <= reg_wdata[1:0];
      if (reg_wr && reg_addr == REG_BG)    bg_color  <= reg_wdata[PIX_W-1:0];
      if (reg_wr && reg_addr == REG_START) clr_start <= aligned_wdata;
      if (start)                           clr_count <= reg_wdata[CNT_W-1:0];
      if (done)        irq <= 1'b1;
      else if (wr_ack) irq <= 1'b0;
    end
  end

  assign active_w = res_mode[1] ? 10'd320 : 10'd640;
  assign active_h = res_mode[0] ? 9'd240 : 9'd480;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_BASE:   reg_rdata[ADDR_W-1:0] = fb_base;
      REG_MODE:   reg_rdata[1:0]        = res_mode;
      REG_BG:     reg_rdata[PIX_W-1:0]  = bg_color;
      REG_START:  reg_rdata[ADDR_W-1:0] = clr_start;
      REG_COUNT:  reg_rdata[CNT_W-1:0]  = clr_count;
      REG_STATUS: begin
        reg_rdata[STAT_BUSY_BIT] = busy;
        reg_rdata[STAT_IRQ_BIT]  = irq;
      end
      default:    reg_rdata = '0;
    endcase
  end

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !wr_ack |=> irq); // R9
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(done)); // R9
  AST_COUNT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_count && busy |=> $stable(clr_count)); // R8
endmodule

// File: rtl/fbc_fill.sv
module fbc_fill
  import fbc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PIX_W       = 16,
  parameter int BUS_W       = 32,
  parameter int CNT_W       = 20,
  parameter int BURST_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  pix_count,
  input  logic [PIX_W-1:0]  fill_color,
  output logic              cmd_valid,
  input  logic              cmd_grant,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              wvalid,
  input  logic              wready,
  output logic [BUS_W-1:0]  wdata,
  output logic [BUS_W/8-1:0] wstrb,
  output logic              busy,
  output logic              done
);
  localparam int BYTES_PER_BEAT = BUS_W / 8;
  localparam int PIX_PER_BEAT   = BUS_W / PIX_W;
  localparam int PIX_BYTES      = PIX_W / 8;
  localparam int BEATS          = BURST_BYTES / BYTES_PER_BEAT;
  localparam int PIX_PER_BURST  = BEATS * PIX_PER_BEAT;
  localparam int BEAT_W         = (BEATS > 1) ? $clog2(BEATS) : 1;

  fill_state_e       state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  remain_q;
  logic [BEAT_W-1:0] beat_q;
  logic [PIX_W-1:0]  color_q;
  logic              beat_fire, last_beat, last_burst;

  assign busy      = (state_q != FS_IDLE);
  assign cmd_valid = (state_q == FS_CMD);
  assign cmd_addr  = addr_q;
  assign wvalid    = (state_q == FS_DATA);
  assign beat_fire = wvalid && wready;
  assign last_beat = (beat_q == BEAT_W'(BEATS - 1));
  assign last_burst = (remain_q <= CNT_W'(PIX_PER_BURST));
  assign done      = beat_fire && last_beat && last_burst;

  for (genvar g = 0; g < PIX_PER_BEAT; g++) begin : g_lane
    logic [CNT_W-1:0] pix_idx;
    assign pix_idx = CNT_W'(beat_q) * CNT_W'(PIX_PER_BEAT) + CNT_W'(g);
    assign wdata[g*PIX_W +: PIX_W]         = color_q;
    assign wstrb[g*PIX_BYTES +: PIX_BYTES] = {PIX_BYTES{remain_q > pix_idx}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= FS_IDLE;
      addr_q   <= '0;
      remain_q <= '0;
      beat_q   <= '0;
      color_q  <= '0;
    end else begin
      case (state_q)
        FS_IDLE: if (start) begin
          state_q  <= FS_CMD;
          addr_q   <= start_addr;
          remain_q <= pix_count;
          color_q  <= fill_color;
        end
        FS_CMD: if (cmd_grant) begin
          state_q <= FS_DATA;
          beat_q  <= '0;
        end
        FS_DATA: if (beat_fire) begin
          if (last_beat) begin
            if (last_burst) state_q <= FS_IDLE;
            else begin
              state_q  <= FS_CMD;
              remain_q <= remain_q - CNT_W'(PIX_PER_BURST);
              addr_q   <= addr_q + ADDR_W'(BURST_BYTES);
            end
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_grant |=> cmd_valid && $stable(cmd_addr)); // R10
  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid && !wready |=> wvalid && $stable(wstrb)); // R10
endmodule

// File: rtl/fbc_arb.sv
module fbc_arb #(
  parameter int ADDR_W = 32
) (
  input  logic              disp_valid,
  output logic              disp_ready,
  input  logic [ADDR_W-1:0] disp_addr,
  input  logic              fill_valid,
  output logic              fill_grant,
  input  logic [ADDR_W-1:0] fill_addr,
  output logic              mem_cmd_valid,
  input  logic              mem_cmd_ready,
  output logic              mem_cmd_write,
  output logic [ADDR_W-1:0] mem_cmd_addr
);
  assign mem_cmd_valid = disp_valid || fill_valid;
  assign mem_cmd_write = !disp_valid;
  assign mem_cmd_addr  = disp_valid ? disp_addr : fill_addr;
  assign disp_ready    = mem_cmd_ready;
  assign fill_grant    = mem_cmd_ready && !disp_valid && fill_valid;
endmodule

// File: rtl/fb_fill_engine.sv
module fb_fill_engine #(
  parameter int ADDR_W      = 32,
  parameter int REG_W       = 32,
  parameter int PIX_W       = 16,
  parameter int BUS_W       = 32,
  parameter int CNT_W       = 20,
  parameter int BURST_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [ADDR_W-1:0] fb_base,
  output logic [1:0]        res_mode,
  output logic [9:0]        active_w,
  output logic [8:0]        active_h,
  output logic [PIX_W-1:0]  bg_color,
  input  logic              disp_valid,
  output logic              disp_ready,
  input  logic [ADDR_W-1:0] disp_addr,
  output logic              mem_cmd_valid,
  input  logic              mem_cmd_ready,
  output logic              mem_cmd_write,
  output logic [ADDR_W-1:0] mem_cmd_addr,
  output logic              mem_wvalid,
  input  logic              mem_wready,
  output logic [BUS_W-1:0]  mem_wdata,
  output logic [BUS_W/8-1:0] mem_wstrb,
  output logic              clr_busy,
  output logic              irq
);
  localparam int ALIGN_BITS = $clog2(BURST_BYTES);

  logic              start, done, fill_valid, fill_grant;
  logic [ADDR_W-1:0] clr_start, fill_addr;
  logic [CNT_W-1:0]  clr_count;

  fbc_regs #(.ADDR_W(ADDR_W), .REG_W(REG_W), .PIX_W(PIX_W), .CNT_W(CNT_W),
             .ALIGN_BITS(ALIGN_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(clr_busy), .done(done),
    .fb_base(fb_base), .res_mode(res_mode), .active_w(active_w), .active_h(active_h),
    .bg_color(bg_color), .clr_start(clr_start), .clr_count(clr_count),
    .start(start), .irq(irq)
  );

  fbc_fill #(.ADDR_W(ADDR_W), .PIX_W(PIX_W), .BUS_W(BUS_W), .CNT_W(CNT_W),
             .BURST_BYTES(BURST_BYTES)) u_fill (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(clr_start),
    .pix_count(reg_wdata[CNT_W-1:0]), .fill_color(bg_color),
    .cmd_valid(fill_valid), .cmd_grant(fill_grant), .cmd_addr(fill_addr),
    .wvalid(mem_wvalid), .wready(mem_wready), .wdata(mem_wdata), .wstrb(mem_wstrb),
    .busy(clr_busy), .done(done)
  );

  fbc_arb #(.ADDR_W(ADDR_W)) u_arb (
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_addr(disp_addr),
    .fill_valid(fill_valid), .fill_grant(fill_grant), .fill_addr(fill_addr),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
    .mem_cmd_write(mem_cmd_write), .mem_cmd_addr(mem_cmd_addr)
  );

  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> clr_busy); // R4
  AST_DISP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> !fill_grant); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_busy |-> !mem_wvalid && !(mem_cmd_valid && mem_cmd_write)); // R10
endmodule

// File: tb/tb_fb_fill_engine.sv
`timescale 1ns/1ps
module tb_fb_fill_engine;
  localparam int WD_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] fb_base;
  logic [1:0] res_mode;
  logic [9:0] active_w;
  logic [8:0] active_h;
  logic [15:0] bg_color;
  logic disp_valid = 1'b0;
  logic disp_ready;
  logic [31:0] disp_addr = '0;
  logic mem_cmd_valid, mem_cmd_write;
  logic mem_cmd_ready = 1'b1;
  logic [31:0] mem_cmd_addr;
  logic mem_wvalid;
  logic mem_wready = 1'b1;
  logic [31:0] mem_wdata;
  logic [3:0] mem_wstrb;
  logic clr_busy, irq;

  always #4 clk = ~clk;

  fb_fill_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fb_base(fb_base),
    .res_mode(res_mode), .active_w(active_w), .active_h(active_h),
    .bg_color(bg_color), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_addr(disp_addr), .mem_cmd_valid(mem_cmd_valid),
    .mem_cmd_ready(mem_cmd_ready), .mem_cmd_write(mem_cmd_write),
    .mem_cmd_addr(mem_cmd_addr), .mem_wvalid(mem_wvalid),
    .mem_wready(mem_wready), .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb),
    .clr_busy(clr_busy), .irq(irq)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;
  bit stall_mode = 0;
  bit disp_en = 0;

  // behavioural reference state
  bit m_busy = 0, m_irq = 0;
  int m_start = 0, m_count = 0, m_cmds = 0, m_beats = 0, m_total = 0;
  int m_start_reg = 0, m_count_reg = 0;
  logic [15:0] m_bg = '0, m_fill = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic observe();
    bit done_now, start_now;
    int p0;
    logic [3:0] es;
    done_now = 0;
    chk(irq == m_irq, "R9 irq level", irq, m_irq);
    chk(clr_busy == m_busy, "R4 busy level", clr_busy, m_busy);
    if (disp_valid) begin
      chk(mem_cmd_valid && !mem_cmd_write && mem_cmd_addr == disp_addr,
          "R7 display owns port", mem_cmd_addr, disp_addr);
      chk(disp_ready == mem_cmd_ready, "R7 display ready", disp_ready, mem_cmd_ready);
    end
    if (!m_busy)
      chk(!mem_wvalid && !(mem_cmd_valid && mem_cmd_write), "R10 idle quiet",
          {mem_wvalid, mem_cmd_valid && mem_cmd_write}, 0);
    if (mem_cmd_valid && mem_cmd_ready && mem_cmd_write) begin
      chk(m_busy && m_beats == m_cmds * 16, "R5 command spacing", m_beats, m_cmds * 16);
      chk(mem_cmd_addr == 32'(m_start + 64 * m_cmds), "R5 burst address",
          mem_cmd_addr, 32'(m_start + 64 * m_cmds));
      m_cmds++;
    end
    if (mem_wvalid && mem_wready) begin
      p0 = m_beats * 2;
      es = {{2{p0 + 1 < m_count}}, {2{p0 < m_count}}};
      chk(m_cmds * 16 > m_beats, "R5 beat after command", m_beats, m_cmds * 16);
      chk(mem_wdata == {m_fill, m_fill}, "R5 fill data", mem_wdata, {m_fill, m_fill});
      chk(mem_wstrb == es, "R6 strobes", mem_wstrb, es);
      m_beats++;
      if (m_beats == m_total) done_now = 1;
    end
    start_now = reg_wr && reg_addr == 3'd4 && !m_busy && reg_wdata[19:0] != 0;
    if (reg_wr && reg_addr == 3'd5 && reg_wdata[1]) m_irq = 0;
    if (done_now) begin m_irq = 1; m_busy = 0; end
    if (start_now) begin
      m_busy = 1; m_start = m_start_reg; m_count = int'(reg_wdata[19:0]);
      m_count_reg = m_count; m_fill = m_bg; m_cmds = 0; m_beats = 0;
      m_total = ((m_count + 31) / 32) * 16;
    end
    if (reg_wr && reg_addr == 3'd2) m_bg = reg_wdata[15:0];
    if (reg_wr && reg_addr == 3'd3) m_start_reg = int'(reg_wdata & 32'hFFFF_FFC0);
  endtask

  task automatic tick();
    cyc++;
    mem_cmd_ready = stall_mode ? (cyc % 3 != 0) : 1'b1;
    mem_wready    = stall_mode ? (cyc % 4 != 1) : 1'b1;
    disp_valid    = disp_en && (cyc % 5 < 2);
    disp_addr     = 32'h0010_0000 + 32'(cyc * 64);
    #2;
    observe();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
    tick();
  endtask

  task automatic wait_idle(input string tag);
    for (int i = 0; i < 4000 && clr_busy; i++) tick();
    chk(!clr_busy && m_beats == m_total, tag, m_beats, m_total);
  endtask

  initial begin
    #(WD_CYCLES * 8);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(!irq && !clr_busy && !mem_wvalid && !mem_cmd_valid, "R1 outputs after reset",
        {irq, clr_busy, mem_wvalid, mem_cmd_valid}, 0);
    for (int a = 0; a < 6; a++) rd(3'(a), 32'h0, "R1 register reset value");

    // R2 / R3: register map, alignment, mode decode
    wr(3'd0, 32'h1234_5678);
    rd(3'd0, 32'h1234_5640, "R2 base alignment");
    chk(fb_base == 32'h1234_5640, "R2 base output", fb_base, 32'h1234_5640);
    for (int m = 0; m < 4; m++) begin
      wr(3'd1, 32'(m));
      rd(3'd1, 32'(m), "R2 mode readback");
      chk(active_w == ((m >= 2) ? 10'd320 : 10'd640), "R3 width", active_w, (m >= 2) ? 320 : 640);
      chk(active_h == ((m % 2 == 1) ? 9'd240 : 9'd480), "R3 height", active_h, (m % 2 == 1) ? 240 : 480);
    end
    wr(3'd2, 32'hFFFF_A5C3);
    rd(3'd2, 32'h0000_A5C3, "R2 colour readback");

    // R4/R5: two full bursts, no stalls
    wr(3'd3, 32'h0000_1000);
    wr(3'd4, 32'd64);
    chk(clr_busy, "R4 busy after launch", clr_busy, 1);
    wait_idle("R5 full bursts complete");
    rd(3'd5, 32'h2, "R9 status after fill");
    repeat (10) tick();
    chk(irq, "R9 interrupt held", irq, 1);
    wr(3'd5, 32'h2);
    chk(!irq, "R9 acknowledge clears", irq, 0);

    // R4: zero count starts nothing
    wr(3'd4, 32'd0);
    chk(!clr_busy, "R4 zero count ignored", clr_busy, 0);
    repeat (3) tick();
    chk(!irq && !mem_wvalid, "R4 zero count no activity", {irq, mem_wvalid}, 0);

    // R5/R6/R7/R8: partial last burst with stalls and display traffic
    stall_mode = 1; disp_en = 1;
    wr(3'd3, 32'h0000_2030);
    rd(3'd3, 32'h0000_2000, "R2 start alignment");
    wr(3'd4, 32'd45);
    for (int i = 0; i < 4000 && clr_busy; i++) begin
      if (i == 5) wr(3'd4, 32'd7);
      else if (i == 10) wr(3'd2, 32'h0000_FFFF);
      else tick();
    end
    chk(!clr_busy && m_beats == m_total, "R5 partial fill complete", m_beats, m_total);
    rd(3'd4, 32'd45, "R8 count unchanged by busy write");
    chk(irq, "R9 interrupt after partial fill", irq, 1);
    wr(3'd5, 32'h2);

    // R6/R9: single pixel, acknowledge held during the whole fill
    stall_mode = 0; disp_en = 0;
    wr(3'd4, 32'd1);
    for (int i = 0; i < 4000 && clr_busy; i++) begin
      reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 32'h2;
      tick();
    end
    reg_wr = 1'b0;
    chk(irq, "R9 completion wins over same-cycle acknowledge", irq, 1);
    chk(m_beats == 16, "R6 single pixel burst length", m_beats, 16);
    rd(3'd5, 32'h2, "R9 status pending");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule